// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer that brings a buck regulator up from zero and recovers it after an overcurrent. The voltage on the soft-start capacitor is represented as an up/down counter, the soft-start level. An internal divider produces one rate tick every `TICK_DIV` clocks. Each tick moves the level one step up while it charges, or one step down while it discharges, so both slopes are equal.

The thresholds are parameters in counter units:

- `LVL_ONE` is the 1 V point.
- `LVL_THREE` is the 3 V point.
- `LVL_CEIL` is the 4 V ceiling.

From the level the block derives the reference code for the error amplifier. With the internal reference, the code is a scaled window of the ramp. With the external reference, the code is a clipped copy of the ramp. The block also produces the drivers-enable flag and the soft-start-done flag.

An overcurrent during the ramp turns the drivers off at once. The discharge, however, is held back until the level has reached the ceiling. An overcurrent at the ceiling starts the discharge at once. A new soft-start begins only after the level has come back to zero. A fault that persists therefore produces a steady hiccup cycle of one full charge followed by one full discharge.

Top module: `ss_hiccup_seq`

## Requirements
- R1: After the active-low reset, the sequencer is idle. The level, reference code, drivers-enable and soft-start-done outputs are all zero.
- R2: The operating condition is `en`, `pg_vcc` and `pg_drv` all high. In any cycle where one of them is low:
  - the next clock edge sets the level to zero, drivers-enable low and soft-start-done low;
  - while the condition stays low, the level stays at zero;
  - when it returns, charging restarts from zero.
- R3: While charging, the level rises by exactly one on each rate tick, once every `TICK_DIV` clocks. It changes at no other time and never exceeds `LVL_CEIL`, where it holds.
- R4: Drivers-enable is high during a normal (fault-free) charge and while running. Soft-start-done rises on the clock after the level reaches `LVL_CEIL` without a fault, and is only ever high with the level at `LVL_CEIL`.
- R5: With the internal reference, the reference code depends on the level as follows:
  - it is 0 for a level at or below `LVL_ONE`;
  - it is `REF_FULL` at or above `LVL_THREE`;
  - between the two it is floor((level-`LVL_ONE`)*`REF_FULL`/(`LVL_THREE`-`LVL_ONE`)).
- R6: With the external reference, the reference code is 0 for a level at or below `LVL_ONE`. Above that it is the smaller of (level-`LVL_ONE`) and `ext_ref_code`.
- R7: `ext_sel` (1 = external) is sampled only while the sequencer is idle. The value seen when charging begins applies until the next return to idle.
- R8: An overcurrent pulse with the level at `LVL_CEIL` has the following effect:
  - on the next clock, drivers-enable and soft-start-done go low;
  - the level then falls by one per rate tick.
- R9: An overcurrent pulse during a normal charge has the following effect:
  - on the next clock, drivers-enable and soft-start-done go low;
  - the level keeps rising to `LVL_CEIL`;
  - only then does the discharge start.
- R10: When a discharge reaches zero, a normal charge with drivers enabled starts again. With the overcurrent held active, successive arrivals of the level at `LVL_CEIL` are exactly 2*`LVL_CEIL`*`TICK_DIV` clocks apart.
- R11: Overcurrent pulses that arrive during a fault charge or a discharge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_vcc | input | 1 | Bias supply good |
| pg_drv | input | 1 | Driver supply good |
| en | input | 1 | Converter enable |
| oc_evt | input | 1 | Overcurrent event pulse |
| ext_sel | input | 1 | 1 selects the external reference |
| ext_ref_code | input | REF_W | External reference value in reference units |
| ref_code | output | REF_W | Reference code for the error amplifier |
| drv_en | output | 1 | Gate drivers enabled |
| ss_done | output | 1 | Soft-start complete |
| ss_level | output | LVL_W | Soft-start level |

## Verification
A state register that is out of step with the level shows up at the ports right away:

- soft-start-done high below the ceiling;
- drivers left on in the clock after an overcurrent;
- a fault ramp that turns back before the ceiling.

A wrong step or a missed tick moves `ss_level` away from the expected count within `TICK_DIV` clocks. A change that breaks only the timing of the hiccup shows up one hiccup period later, as a wrong spacing between arrivals at the ceiling. An error in the reference scaling is seen at the window points, that is, the 1 V, 2 V and 3 V levels and the external clip, in the same cycle the level gets there.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_CHARGE  = 3'd1,
    ST_RUN     = 3'd2,
    ST_FLT_CHG = 3'd3,
    ST_DISCH   = 3'd4
  } ssq_state_t;

  // Scaled reference inside the window [one, three], clamped outside it.
  function automatic int unsigned ref_internal(
    input int unsigned lvl,
    input int unsigned one,
    input int unsigned three,
    input int unsigned full
  );
    if (lvl <= one)
      return 0;
    else if (lvl >= three)
      return full;
    else
      return ((lvl - one) * full) / (three - one);
  endfunction

  // Ramp above one at unit slope, clipped at the external value.
  function automatic int unsigned ref_external(
    input int unsigned lvl,
    input int unsigned one,
    input int unsigned ext
  );
    int unsigned d;
    if (lvl <= one)
      return 0;
    d = lvl - one;
    return (d > ext) ? ext : d;
  endfunction

endpackage

// File: rtl/ssq_tick.sv
module ssq_tick #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_q == LAST)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ssq_level.sv
module ssq_level #(
  parameter int unsigned LVL_CEIL = 400,
  parameter int unsigned LVL_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             up,
  input  logic             down,
  output logic [LVL_W-1:0] level,
  output logic             at_top,
  output logic             at_zero
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LVL_CEIL);

  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl_q <= '0;
    else if (clear)
      lvl_q <= '0;
    else if (tick && up && (lvl_q != TOP))
      lvl_q <= lvl_q + 1'b1;
    else if (tick && down && (lvl_q != '0))
      lvl_q <= lvl_q - 1'b1;
  end

  assign level   = lvl_q;
  assign at_top  = (lvl_q == TOP);
  assign at_zero = (lvl_q == '0);
endmodule

// File: rtl/ssq_ref.sv
module ssq_ref
  import ssq_pkg::*;
#(
  parameter int unsigned LVL_W     = 9,
  parameter int unsigned REF_W     = 10,
  parameter int unsigned LVL_ONE   = 100,
  parameter int unsigned LVL_THREE = 300,
  parameter int unsigned REF_FULL  = 597
) (
  input  logic [LVL_W-1:0] level,
  input  logic             sel_ext,
  input  logic [REF_W-1:0] ext_code,
  output logic [REF_W-1:0] ref_code
);
  int unsigned lv;
  int unsigned ev;

  always_comb begin
    lv = 32'(level);
    ev = 32'(ext_code);
    if (sel_ext)
      ref_code = REF_W'(ref_external(lv, LVL_ONE, ev));
    else
      ref_code = REF_W'(ref_internal(lv, LVL_ONE, LVL_THREE, REF_FULL));
  end
endmodule

// File: rtl/ssq_fsm.sv
module ssq_fsm
  import ssq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate,
  input  logic       oc_evt,
  input  logic       at_top,
  input  logic       at_zero,
  input  logic       ext_sel,
  output ssq_state_t state,
  output logic       up,
  output logic       down,
  output logic       drv_en,
  output logic       ss_done,
  output logic       sel_ext
);
  ssq_state_t st_q, st_d;
  logic       sel_q;

  always_comb begin
    st_d = st_q;
    if (!gate) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:     st_d = ST_CHARGE;
        ST_CHARGE: begin
          if (oc_evt)      st_d = at_top ? ST_DISCH : ST_FLT_CHG;
          else if (at_top) st_d = ST_RUN;
        end
        ST_RUN:     if (oc_evt)  st_d = ST_DISCH;
        ST_FLT_CHG: if (at_top)  st_d = ST_DISCH;
        ST_DISCH:   if (at_zero) st_d = ST_CHARGE;
        default:    st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      sel_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_OFF) sel_q <= ext_sel;
    end
  end

  assign state   = st_q;
  assign up      = (st_q == ST_CHARGE) || (st_q == ST_FLT_CHG);
  assign down    = (st_q == ST_DISCH);
  assign drv_en  = (st_q == ST_CHARGE) || (st_q == ST_RUN);
  assign ss_done = (st_q == ST_RUN);
  assign sel_ext = sel_q;
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq
  import ssq_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 4,
  parameter int unsigned LVL_ONE   = 100,
  parameter int unsigned LVL_THREE = 300,
  parameter int unsigned LVL_CEIL  = 400,
  parameter int unsigned REF_FULL  = 597,
  parameter int unsigned REF_W     = 10,
  parameter int unsigned LVL_W     = $clog2(LVL_CEIL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_vcc,
  input  logic             pg_drv,
  input  logic             en,
  input  logic             oc_evt,
  input  logic             ext_sel,
  input  logic [REF_W-1:0] ext_ref_code,
  output logic [REF_W-1:0] ref_code,
  output logic             drv_en,
  output logic             ss_done,
  output logic [LVL_W-1:0] ss_level
);
  // Named internal events, visible to the bound checker.
  logic       gate;
  logic       tick;
  logic       up, down;
  logic       at_top, at_zero;
  logic       sel_ext;
  ssq_state_t state;

  assign gate = en & pg_vcc & pg_drv;

  ssq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  ssq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate   (gate),
    .oc_evt (oc_evt),
    .at_top (at_top),
    .at_zero(at_zero),
    .ext_sel(ext_sel),
    .state  (state),
    .up     (up),
    .down   (down),
    .drv_en (drv_en),
    .ss_done(ss_done),
    .sel_ext(sel_ext)
  );

  ssq_level #(.LVL_CEIL(LVL_CEIL), .LVL_W(LVL_W)) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!gate),
    .tick   (tick),
    .up     (up),
    .down   (down),
    .level  (ss_level),
    .at_top (at_top),
    .at_zero(at_zero)
  );

  ssq_ref #(
    .LVL_W    (LVL_W),
    .REF_W    (REF_W),
    .LVL_ONE  (LVL_ONE),
    .LVL_THREE(LVL_THREE),
    .REF_FULL (REF_FULL)
  ) u_ref (
    .level   (ss_level),
    .sel_ext (sel_ext),
    .ext_code(ext_ref_code),
    .ref_code(ref_code)
  );
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker
  import ssq_pkg::*;
#(
  parameter int unsigned LVL_ONE  = 100,
  parameter int unsigned LVL_CEIL = 400,
  parameter int unsigned REF_FULL = 597,
  parameter int unsigned REF_W    = 10,
  parameter int unsigned LVL_W    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic             tick,
  input logic             oc_evt,
  input ssq_state_t       state,
  input logic             sel_ext,
  input logic [LVL_W-1:0] level,
  input logic [REF_W-1:0] ref_code,
  input logic             drv_en,
  input logic             ss_done
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LVL_CEIL);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(LVL_ONE);
  localparam logic [REF_W-1:0] RMX = REF_W'(REF_FULL);

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP); // R3
  AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !tick) |=> $stable(level)); // R3
  AST_GATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (level == '0 && !drv_en && !ss_done)); // R2
  AST_DONE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (level == TOP && drv_en)); // R4
  AST_OC_CUTS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && oc_evt && drv_en) |=> (!drv_en && !ss_done)); // R8
  AST_DISCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && state == ST_DISCH && tick && level != '0)
      |=> (level == LVL_W'($past(level) - 1'b1))); // R8
  AST_FAULT_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && (state == ST_FLT_CHG || (state == ST_DISCH && level != '0)))
      |=> !drv_en); // R11
  AST_REF_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= ONE) |-> (ref_code == '0)); // R5
  AST_REF_INT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ext |-> (ref_code <= RMX)); // R5
endmodule

bind ss_hiccup_seq ssq_checker #(
  .LVL_ONE (LVL_ONE),
  .LVL_CEIL(LVL_CEIL),
  .REF_FULL(REF_FULL),
  .REF_W   (REF_W),
  .LVL_W   (LVL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate    (gate),
  .tick    (tick),
  .oc_evt  (oc_evt),
  .state   (state),
  .sel_ext (sel_ext),
  .level   (ss_level),
  .ref_code(ref_code),
  .drv_en  (drv_en),
  .ss_done (ss_done)
);

// File: tb/ss_hiccup_seq_tb.sv
module ss_hiccup_seq_tb;
  localparam int DIV   = 4;
  localparam int ONE   = 100;
  localparam int THREE = 300;
  localparam int CEIL  = 400;
  localparam int FULL  = 597;
  localparam int RW    = 10;
  localparam int LW    = $clog2(CEIL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_vcc = 1'b0, pg_drv = 1'b0, en = 1'b0, oc_evt = 1'b0, ext_sel = 1'b0;
  logic [RW-1:0] ext_ref_code = '0;
  logic [RW-1:0] ref_code;
  logic drv_en, ss_done;
  logic [LW-1:0] ss_level;

  int n_chk = 0, n_fail = 0;
  int cyc_n = 0;
  bit started = 0;

  always #5 clk = ~clk;

  ss_hiccup_seq #(
    .TICK_DIV(DIV), .LVL_ONE(ONE), .LVL_THREE(THREE), .LVL_CEIL(CEIL),
    .REF_FULL(FULL), .REF_W(RW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pg_vcc(pg_vcc), .pg_drv(pg_drv), .en(en),
    .oc_evt(oc_evt), .ext_sel(ext_sel), .ext_ref_code(ext_ref_code),
    .ref_code(ref_code), .drv_en(drv_en), .ss_done(ss_done), .ss_level(ss_level)
  );

  // Behavioural reference model: 0 idle, 1 ramp, 2 running, 3 fault ramp, 4 drain
  int m_mode = 0, m_lvl = 0, m_div = 0;
  bit m_ext = 0;

  function automatic int exp_ref(int lvl, bit ext, int ext_v);
    int r;
    if (lvl <= ONE) return 0;
    if (ext) begin
      r = lvl - ONE;
      if (r > ext_v) r = ext_v;
      return r;
    end
    if (lvl >= THREE) return FULL;
    return ((lvl - ONE) * FULL) / (THREE - ONE);
  endfunction

  always @(posedge clk) begin
    automatic bit ok = en && pg_vcc && pg_drv;
    automatic bit stp = (m_div == DIV - 1);
    automatic int nm = m_mode;
    automatic int nl = m_lvl;
    cyc_n++;
    if (!rst_n) begin
      m_mode = 0; m_lvl = 0; m_div = 0; m_ext = 0;
    end else begin
      started = 1;
      if (m_mode == 0) m_ext = ext_sel;
      if (!ok) begin
        nm = 0; nl = 0;
      end else begin
        if (m_mode == 0) nm = 1;
        else if (m_mode == 1) begin
          if (oc_evt) nm = (m_lvl == CEIL) ? 4 : 3;
          else if (m_lvl == CEIL) nm = 2;
        end else if (m_mode == 2) begin
          if (oc_evt) nm = 4;
        end else if (m_mode == 3) begin
          if (m_lvl == CEIL) nm = 4;
        end else if (m_lvl == 0) nm = 1;
        if (stp && (m_mode == 1 || m_mode == 3) && m_lvl < CEIL) nl = m_lvl + 1;
        else if (stp && m_mode == 4 && m_lvl > 0) nl = m_lvl - 1;
      end
      m_mode = nm; m_lvl = nl;
      m_div = stp ? 0 : m_div + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      chk(int'(ss_level) == m_lvl, "R3 level", int'(ss_level), m_lvl);
      chk(drv_en == (m_mode == 1 || m_mode == 2), "R4 drv_en", int'(drv_en),
          int'(m_mode == 1 || m_mode == 2));
      chk(ss_done == (m_mode == 2), "R4 ss_done", int'(ss_done), int'(m_mode == 2));
      chk(int'(ref_code) == exp_ref(m_lvl, m_ext, int'(ext_ref_code)), "R5/R6 ref",
          int'(ref_code), exp_ref(m_lvl, m_ext, int'(ext_ref_code)));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(int v);
    for (int i = 0; i < 20000; i++) begin
      if (int'(ss_level) == v) return;
      @(negedge clk);
    end
    chk(0, "wait level", int'(ss_level), v);
  endtask

  task automatic pulse_oc();
    oc_evt = 1'b1;
    cyc(1);
    oc_evt = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc_n > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_n, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t1, t2;
    cyc(3);
    // R1 reset state
    chk(ss_level == 0 && ref_code == 0 && !drv_en && !ss_done, "R1 reset",
        int'(ss_level) + int'(ref_code) + int'(drv_en) + int'(ss_done), 0);
    rst_n = 1'b1;
    cyc(10);
    chk(ss_level == 0, "R2 idle without enable", int'(ss_level), 0);
    pg_vcc = 1; pg_drv = 1; en = 1; ext_sel = 0; ext_ref_code = 150;
    cyc(2);
    chk(drv_en == 1, "R4 drivers on in ramp", int'(drv_en), 1);
    wait_level(ONE);
    chk(ref_code == 0, "R5 ref at 1V", int'(ref_code), 0);
    wait_level(200);
    chk(int'(ref_code) == 298, "R5 ref at 2V", int'(ref_code), 298);
    wait_level(THREE);
    chk(int'(ref_code) == FULL, "R5 ref at 3V", int'(ref_code), FULL);
    wait_level(CEIL);
    cyc(1);
    chk(ss_done == 1, "R4 done after ceiling", int'(ss_done), 1);
    cyc(40);
    chk(int'(ss_level) == CEIL, "R3 hold at ceiling", int'(ss_level), CEIL);

    // R8 overcurrent at the ceiling
    pulse_oc();
    chk(!drv_en && !ss_done, "R8 drive cut", int'(drv_en) + int'(ss_done), 0);
    cyc(DIV * 10 + 1);
    chk(int'(ss_level) < CEIL - 5, "R8 discharging", int'(ss_level), CEIL - 10);
    // R11 pulse during discharge ignored
    pulse_oc();
    cyc(DIV * 3);
    chk(!drv_en && int'(ss_level) < CEIL - 10, "R11 ignored in discharge",
        int'(ss_level), CEIL - 13);
    wait_level(0);
    cyc(2);
    chk(drv_en == 1, "R10 restart after zero", int'(drv_en), 1);

    // R9 overcurrent during the ramp
    wait_level(150);
    pulse_oc();
    chk(!drv_en && !ss_done, "R9 drive cut in ramp", int'(drv_en) + int'(ss_done), 0);
    cyc(DIV * 5 + 1);
    chk(int'(ss_level) > 150, "R9 keeps rising", int'(ss_level), 155);
    pulse_oc(); // R11: ignored during fault ramp
    wait_level(CEIL);
    cyc(DIV * 4 + 2);
    chk(int'(ss_level) < CEIL && !drv_en, "R9 discharge after ceiling",
        int'(ss_level), CEIL - 4);
    wait_level(0);
    wait_level(CEIL);
    cyc(2);
    chk(ss_done == 1, "R10 normal finish", int'(ss_done), 1);

    // R10 hiccup period with persistent fault
    oc_evt = 1;
    wait_level(CEIL - 1);
    wait_level(CEIL);
    t1 = cyc_n;
    wait_level(CEIL - 1);
    wait_level(CEIL);
    t2 = cyc_n;
    chk(t2 - t1 == 2 * CEIL * DIV, "R10 hiccup period", t2 - t1, 2 * CEIL * DIV);
    oc_evt = 0;
    wait_level(0);
    wait_level(CEIL);
    cyc(2);

    // R2 enable and supply drops
    en = 0; cyc(1); en = 1;
    chk(ss_level == 0 && !drv_en && !ss_done, "R2 enable drop", int'(ss_level), 0);
    wait_level(50);
    pg_drv = 0; cyc(1);
    chk(ss_level == 0 && !drv_en, "R2 supply drop", int'(ss_level), 0);
    cyc(50);
    chk(ss_level == 0, "R2 held at zero", int'(ss_level), 0);

    // R6 external reference, R7 capture
    ext_sel = 1; cyc(2); pg_drv = 1;
    wait_level(200);
    chk(int'(ref_code) == 100, "R6 ext tracking", int'(ref_code), 100);
    ext_sel = 0;
    wait_level(THREE);
    chk(int'(ref_code) == 150, "R6 ext clip / R7 held", int'(ref_code), 150);
    en = 0; cyc(3); en = 1;
    wait_level(THREE);
    chk(int'(ref_code) == FULL, "R7 new selection", int'(ref_code), FULL);

    cyc(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule